// File: doc/BRIEF.md
# SPI Slave Register Access Frontend

This block is an SPI slave that lets an external master read and write 32-bit registers on an on-chip register bus. The register space is split into blocks and subblocks, and each register inside a pair has an 8-bit address. The master sends one byte-oriented frame per access. The slave decodes the frame, checks the block and subblock pair against a fixed table of legal pairs, and issues one request on a simple register bus. For a read, it shifts the returned word back out on MISO.

SCLK, chip select and MOSI are sampled by the fabric clock `clk`, which must be many times faster than SCLK. Each input passes through a synchronizer, and the edges of SCLK are then detected in the `clk` domain. Every request and bus output comes from a register.

The register bus has a fixed read latency. Read data is valid on `reg_rdata` during the cycle that comes `RD_LATENCY` cycles after the cycle in which `reg_req` is high.

Top module: `sra_spi_frontend`

## Requirements
- R1: SPI mode 0 is used. SCLK idles low, MOSI is sampled on rising SCLK edges, and every byte travels most significant bit first.
- R2: The first byte of a frame is the command. Bits [7:5] hold the block number, bit 4 holds the direction (1 = write, 0 = read), and bits [3:0] hold the subblock number. These values appear on `reg_blk`, `reg_we` and `reg_sub` with the request.
- R3: The second byte of a frame is the register address, and it appears on `reg_addr` with the request.
- R4: A write frame is the command byte, the address byte and four data bytes. The data bytes go most significant first. Exactly one request with `reg_we`=1 and the assembled word on `reg_wdata` is issued, and only after the last data bit has been received.
- R5: A read frame is the command byte, the address byte, two filler bytes and four response bytes. One request with `reg_we`=0 is issued once the address byte is complete. The 32-bit result is shifted out MSB first during the response bytes, and MISO changes on falling SCLK edges.
- R6: The legal pairs are as follows. Block 1 accepts subblocks 0, 1, 2, 3, 4 and 6. Blocks 2 and 7 accept subblock 0 only. Blocks 3, 4 and 5 accept subblocks 0 and 1. Every other pair is illegal.
- R7: An access to an illegal pair never asserts `reg_req`. A read of an illegal pair returns 32'hFFFFFFFF.
- R8: If chip select is released before a write frame is complete, no request is issued and the target register keeps its previous value. A later full frame is handled normally.
- R9: MISO is 0 while chip select is inactive, and it is 0 during the command, address and filler bytes of a read.
- R10: While reset is held, and in the cycle after it, `reg_req` and `spi_miso` are 0.
- R11: `reg_req` is a pulse of exactly one `clk` cycle per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 0 when not selected |
| reg_req | output | 1 | One-cycle register bus request strobe |
| reg_we | output | 1 | 1 = write request, 0 = read request |
| reg_blk | output | 3 | Block number of the request |
| reg_sub | output | 4 | Subblock number of the request |
| reg_addr | output | 8 | Register address of the request |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid RD_LATENCY cycles after the request cycle |

## Verification
The bound assertions check four properties on every cycle:
- no request is ever raised for an illegal block and subblock pair;
- every request is a single-cycle pulse that starts inside an active chip select;
- MISO falls to 0 whenever the slave is deselected;
- the outputs are quiet in reset.

Only the bench's frames can show the following:
- command byte decode and MSB-first assembly of the write word;
- the timing of the read response relative to the filler bytes;
- the all-ones answer for illegal reads;
- that an aborted write leaves the register unchanged.

// File: rtl/sra_pkg.sv
package sra_pkg;

  // Decoded command byte: block, direction, subblock (bit order is fixed by the frame format)
  typedef struct packed {
    logic [2:0] blk;
    logic       wr;
    logic [3:0] sub;
  } sra_cmd_t;

  // Legality table of block/subblock pairs
  function automatic logic pair_legal(input logic [2:0] blk, input logic [3:0] sub);
    logic ok;
    case (blk)
      3'd1:             ok = (sub <= 4'd4) || (sub == 4'd6);
      3'd2, 3'd7:       ok = (sub == 4'd0);
      3'd3, 3'd4, 3'd5: ok = (sub <= 4'd1);
      default:          ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sra_addr_filter.sv
module sra_addr_filter (
  input  logic [2:0] blk,
  input  logic [3:0] sub,
  output logic       legal
);
  always_comb legal = sra_pkg::pair_legal(blk, sub);
endmodule

// File: rtl/sra_tx_shift.sv
module sra_tx_shift #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] load_data,
  output logic              bit_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sh_q  <= '0;
      bit_o <= 1'b0;
    end else if (load) begin
      sh_q  <= load_data;
      bit_o <= load_data[DATA_W-1];
    end else if (shift) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
      bit_o <= sh_q[DATA_W-2];
    end
  end
endmodule

// File: rtl/sra_spi_frontend.sv
module sra_spi_frontend #(
  parameter int DATA_W       = 32,
  parameter int BYTE_W       = 8,
  parameter int FILLER_BYTES = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int RD_LATENCY   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_req,
  output logic              reg_we,
  output logic [2:0]        reg_blk,
  output logic [3:0]        reg_sub,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  import sra_pkg::*;

  localparam int DATA_BYTES = DATA_W / BYTE_W;
  localparam int WR_LAST_I  = 2 + DATA_BYTES - 1;
  localparam int RESP_FST_I = 2 + FILLER_BYTES;
  localparam int RESP_LST_I = RESP_FST_I + DATA_BYTES - 1;
  localparam int IDX_MAX_I  = RESP_LST_I + 1;
  localparam int IDX_W      = $clog2(IDX_MAX_I + 1);
  localparam int CNT_W      = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_DAT0 = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_WLST = IDX_W'(WR_LAST_I);
  localparam logic [IDX_W-1:0] IDX_RFST = IDX_W'(RESP_FST_I);
  localparam logic [IDX_W-1:0] IDX_RLST = IDX_W'(RESP_LST_I);
  localparam logic [IDX_W-1:0] IDX_MAX  = IDX_W'(IDX_MAX_I);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

  // input synchronisation and SCLK edge detection
  logic s_sclk, s_csn, s_mosi, sclk_q;
  logic cs_act, rise, fall;

  sra_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({spi_sclk, spi_cs_n, spi_mosi}),
    .dout({s_sclk, s_csn, s_mosi})
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= s_sclk;
  end

  assign cs_act = !s_csn;
  assign rise   = cs_act && s_sclk && !sclk_q;
  assign fall   = cs_act && !s_sclk && sclk_q;

  // frame position and receive path
  logic [CNT_W-1:0]  bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-2:0] shift_in;
  logic [BYTE_W-1:0] byte_in;
  logic [DATA_W-1:0] wacc;
  sra_cmd_t          cmd_q;
  logic              legal;
  logic              byte_done;

  assign byte_in   = {shift_in, s_mosi};
  assign byte_done = rise && (bit_cnt == BIT_LAST);

  sra_addr_filter u_filter (
    .blk  (cmd_q.blk),
    .sub  (cmd_q.sub),
    .legal(legal)
  );

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      bit_cnt  <= '0;
      byte_idx <= '0;
      shift_in <= '0;
    end else if (rise) begin
      shift_in <= byte_in[BYTE_W-2:0];
      bit_cnt  <= (bit_cnt == BIT_LAST) ? '0 : bit_cnt + 1'b1;
      if (bit_cnt == BIT_LAST && byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
    end
  end

  // command, address and write-data capture; request generation
  logic issue_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q     <= '0;
      wacc      <= '0;
      reg_req   <= 1'b0;
      reg_we    <= 1'b0;
      reg_blk   <= '0;
      reg_sub   <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_req <= 1'b0;
      if (byte_done) begin
        if (byte_idx == '0) cmd_q <= sra_cmd_t'(byte_in);
        if (byte_idx == IDX_ADDR) begin
          reg_addr <= byte_in;
          reg_blk  <= cmd_q.blk;
          reg_sub  <= cmd_q.sub;
          if (!cmd_q.wr && legal) begin
            reg_req <= 1'b1;
            reg_we  <= 1'b0;
          end
        end
        if (cmd_q.wr && byte_idx >= IDX_DAT0 && byte_idx <= IDX_WLST) begin
          wacc <= {wacc[DATA_W-BYTE_W-1:0], byte_in};
          if (byte_idx == IDX_WLST && legal) begin
            reg_req   <= 1'b1;
            reg_we    <= 1'b1;
            reg_wdata <= {wacc[DATA_W-BYTE_W-1:0], byte_in};
          end
        end
      end
    end
  end

  assign issue_rd = byte_done && (byte_idx == IDX_ADDR) && !cmd_q.wr && legal;

  // read data capture after the fixed bus latency
  logic [RD_LATENCY:0] rd_pipe;
  logic [DATA_W-1:0]   rd_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pipe <= '0;
      rd_hold <= '0;
    end else begin
      rd_pipe <= {rd_pipe[RD_LATENCY-1:0], issue_rd};
      if (rd_pipe[RD_LATENCY]) rd_hold <= reg_rdata;
    end
  end

  // response serialisation
  logic in_resp, tx_load, tx_shift, tx_clear;
  logic [DATA_W-1:0] tx_data;

  assign in_resp  = !cmd_q.wr && byte_idx >= IDX_RFST && byte_idx <= IDX_RLST;
  assign tx_load  = fall && in_resp && byte_idx == IDX_RFST && bit_cnt == '0;
  assign tx_shift = fall && in_resp && !tx_load;
  assign tx_clear = !cs_act || (fall && !in_resp);
  assign tx_data  = legal ? rd_hold : '1;

  sra_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .clear    (tx_clear),
    .load     (tx_load),
    .shift    (tx_shift),
    .load_data(tx_data),
    .bit_o    (spi_miso)
  );
endmodule

// File: rtl/sra_spi_frontend_chk.sv
module sra_spi_frontend_chk (
  input logic       clk,
  input logic       rst,
  input logic       cs_act,
  input logic       reg_req,
  input logic [2:0] reg_blk,
  input logic [3:0] reg_sub,
  input logic       spi_miso
);
  // R7
  illegal_pair_chk: assert property (@(posedge clk) disable iff (rst)
    reg_req |-> sra_pkg::pair_legal(reg_blk, reg_sub));

  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_req |=> !reg_req);

  // R8
  req_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    reg_req |-> $past(cs_act));

  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_act |=> !spi_miso);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!reg_req && !spi_miso));
endmodule

bind sra_spi_frontend sra_spi_frontend_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_act  (cs_act),
  .reg_req (reg_req),
  .reg_blk (reg_blk),
  .reg_sub (reg_sub),
  .spi_miso(spi_miso)
);

// File: tb/sim_sra_spi_frontend.sv
module sim_sra_spi_frontend;
  localparam int HALF = 8;
  localparam int NVEC = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, reg_req, reg_we;
  logic [2:0] reg_blk;
  logic [3:0] reg_sub;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;

  always #2 clk = ~clk;

  sra_spi_frontend u0 (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .reg_req(reg_req), .reg_we(reg_we), .reg_blk(reg_blk),
    .reg_sub(reg_sub), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // register bus model: read data one cycle after the request
  logic [31:0] mem [logic [14:0]];
  int req_cnt = 0, double_cnt = 0;
  logic prev_req = 1'b0;
  logic l_we; logic [2:0] l_blk; logic [3:0] l_sub; logic [7:0] l_addr; logic [31:0] l_wdata;

  function automatic logic [31:0] dflt(input logic [14:0] k);
    return 32'h5A000000 | {17'b0, k};
  endfunction

  always @(posedge clk) begin
    prev_req <= reg_req;
    if (reg_req && prev_req) double_cnt <= double_cnt + 1;
    if (reg_req) begin
      req_cnt <= req_cnt + 1;
      l_we <= reg_we; l_blk <= reg_blk; l_sub <= reg_sub;
      l_addr <= reg_addr; l_wdata <= reg_wdata;
      if (reg_we) mem[{reg_blk, reg_sub, reg_addr}] = reg_wdata;
      else reg_rdata <= mem.exists({reg_blk, reg_sub, reg_addr}) ?
                        mem[{reg_blk, reg_sub, reg_addr}] : dflt({reg_blk, reg_sub, reg_addr});
    end
  end

  logic [31:0] shadow [logic [14:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(posedge clk); #1;
      sclk = 1'b1;
      rx[i] = miso;
      repeat (HALF) @(posedge clk); #1;
      sclk = 1'b0;
    end
  endtask

  // nbytes < full frame length gives an aborted frame
  task automatic do_frame(input logic we, input logic [2:0] b, input logic [3:0] s,
                          input logic [7:0] a, input logic [31:0] d, input int nbytes,
                          output logic [31:0] resp, output logic [31:0] lead);
    logic [7:0] tx [8];
    logic [7:0] rx;
    tx[0] = {b, we, s}; tx[1] = a;
    if (we) begin
      tx[2] = d[31:24]; tx[3] = d[23:16]; tx[4] = d[15:8]; tx[5] = d[7:0];
      tx[6] = 8'h00; tx[7] = 8'h00;
    end else begin
      for (int i = 2; i < 8; i++) tx[i] = 8'h00;
    end
    resp = '0; lead = '0;
    #1 cs_n = 1'b0;
    repeat (HALF) @(posedge clk);
    for (int i = 0; i < nbytes; i++) begin
      spi_byte(tx[i], rx);
      if (i < 4) lead[31-8*i -: 8] = rx;
      else       resp[31-8*(i-4) -: 8] = rx;
    end
    repeat (HALF) @(posedge clk); #1;
    cs_n = 1'b1;
    repeat (4*HALF) @(posedge clk);
  endtask

  // {we, blk, sub, addr, data, legal}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b1, 3'd1, 4'd0, 8'h10, 32'hDEADBEEF, 1'b1},
    {1'b0, 3'd1, 4'd0, 8'h10, 32'h0,        1'b1},
    {1'b1, 3'd1, 4'd6, 8'h19, 32'h00000034, 1'b1},
    {1'b0, 3'd1, 4'd6, 8'h19, 32'h0,        1'b1},
    {1'b1, 3'd1, 4'd5, 8'h01, 32'h12345678, 1'b0},
    {1'b0, 3'd1, 4'd5, 8'h01, 32'h0,        1'b0},
    {1'b1, 3'd7, 4'd0, 8'h05, 32'h00000033, 1'b1},
    {1'b0, 3'd7, 4'd1, 8'h05, 32'h0,        1'b0},
    {1'b1, 3'd3, 4'd1, 8'hA5, 32'h80000001, 1'b1},
    {1'b0, 3'd3, 4'd1, 8'hA5, 32'h0,        1'b1},
    {1'b0, 3'd2, 4'd0, 8'h18, 32'h0,        1'b1},
    {1'b1, 3'd0, 4'd0, 8'h00, 32'hCAFEF00D, 1'b0},
    {1'b0, 3'd6, 4'd0, 8'h22, 32'h0,        1'b0},
    {1'b0, 3'd5, 4'd1, 8'h7F, 32'h0,        1'b1},
    {1'b1, 3'd4, 4'd2, 8'h44, 32'h0F0F0F0F, 1'b0}
  };

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] resp, lead, exp;
    int c0;
    logic [14:0] k;
    repeat (6) @(posedge clk);
    @(negedge clk);
    // R10: outputs quiet in reset
    chk("R10 miso in reset", {31'b0, miso}, 32'h0);
    chk("R10 req in reset", {31'b0, reg_req}, 32'h0);
    rst = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk("R10 miso after reset", {31'b0, miso}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic we, lg; logic [2:0] b; logic [3:0] s; logic [7:0] a; logic [31:0] d;
      {we, b, s, a, d, lg} = VEC[v];
      k = {b, s, a};
      c0 = req_cnt;
      do_frame(we, b, s, a, d, we ? 6 : 8, resp, lead);
      if (we) begin
        // R4 R6 R7: one request per legal write, none for illegal
        chk("R4/R6/R7 write request count", req_cnt - c0, lg ? 1 : 0);
        if (lg) begin
          chk("R2 block", {29'b0, l_blk}, {29'b0, b});
          chk("R2 subblock", {28'b0, l_sub}, {28'b0, s});
          chk("R2 direction", {31'b0, l_we}, 32'h1);
          chk("R3 address", {24'b0, l_addr}, {24'b0, a});
          chk("R1/R4 write data MSB first", l_wdata, d);
          shadow[k] = d;
        end
      end else begin
        chk("R5/R6/R7 read request count", req_cnt - c0, lg ? 1 : 0);
        if (lg) begin
          chk("R2 read direction", {31'b0, l_we}, 32'h0);
          chk("R3 read address", {24'b0, l_addr}, {24'b0, a});
          exp = shadow.exists(k) ? shadow[k] : dflt(k);
        end else exp = 32'hFFFFFFFF;
        chk("R5/R7 read response", resp, exp);
        chk("R9 miso low in cmd/filler bytes", lead, 32'h0);
      end
      @(negedge clk);
      chk("R9 miso low after deselect", {31'b0, miso}, 32'h0);
    end

    // R8: write aborted after three of four data bytes
    c0 = req_cnt;
    do_frame(1'b1, 3'd1, 4'd0, 8'h10, 32'h01020304, 5, resp, lead);
    chk("R8 aborted write issues no request", req_cnt - c0, 0);
    do_frame(1'b0, 3'd1, 4'd0, 8'h10, 32'h0, 8, resp, lead);
    chk("R8 register unchanged after abort", resp, 32'hDEADBEEF);
    // R8: abort right after the command byte, then a full write
    do_frame(1'b1, 3'd1, 4'd0, 8'h10, 32'h0, 1, resp, lead);
    c0 = req_cnt;
    do_frame(1'b1, 3'd1, 4'd0, 8'h10, 32'h11223344, 6, resp, lead);
    chk("R8 full write after abort", req_cnt - c0, 1);
    do_frame(1'b0, 3'd1, 4'd0, 8'h10, 32'h0, 8, resp, lead);
    chk("R5 read back after abort", resp, 32'h11223344);
    // R6: edge subblocks of block 1
    c0 = req_cnt;
    do_frame(1'b0, 3'd1, 4'd4, 8'h00, 32'h0, 8, resp, lead);
    chk("R6 block1 sub4 legal", req_cnt - c0, 1);
    chk("R6 block1 sub4 response", resp, dflt({3'd1, 4'd4, 8'h00}));
    c0 = req_cnt;
    do_frame(1'b0, 3'd2, 4'd1, 8'h00, 32'h0, 8, resp, lead);
    chk("R6 block2 sub1 illegal", req_cnt - c0, 0);
    chk("R7 block2 sub1 ones", resp, 32'hFFFFFFFF);
    // R11: no request lasted more than one cycle
    chk("R11 single-cycle requests", double_cnt, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule